// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block tells the fetch stage, in the same cycle that a fetch address is presented, whether that address belongs to a known branch and which address to fetch next. It is a direct-mapped table. Each slot holds a valid flag, the upper address bits of the branch that installed it, and the address that branch jumped to.

The lookup is purely combinational. The fetch address selects one slot through its word-index bits. The slot reports a hit only when it is valid and its stored upper bits equal those of the fetch address. The block does not decide direction: a separate direction predictor supplies a taken flag. The stored target is used only when the slot hits and that flag is set. In every other case fetch continues at the next sequential word.

A single write port from the branch-resolve stage installs a resolved taken branch. The write overwrites whatever slot the branch address maps to, and the new contents become visible on the next cycle.

The lookup outcome is an enumerated kind with three values:
- `LK_MISS`: no valid matching slot.
- `LK_HIT_FALL`: the slot matches and the predictor says not taken.
- `LK_HIT_JUMP`: the slot matches and the predictor says taken.

The transitions of a slot are named as follows:
- Reset clears the slot to empty.
- An install moves the slot from empty to occupied.
- A replace moves the slot from occupied to occupied, with a new owner.

Top module: `fetch_target_buffer`

## Requirements
- R1: While reset is asserted (active-low) and after it is released, every slot is empty, so every lookup misses until an install happens.
- R2: With the default 32-bit address and 16 slots, address bits [5:2] select the slot and bits [31:6] form the tag. A lookup hits only if that slot is valid and its stored tag equals the fetch address's bits [31:6].
- R3: On a hit with the taken flag high, `hit` is 1 and `next_pc` equals the stored target.
- R4: On a miss, `hit` is 0 and `next_pc` equals `fetch_pc + 4`, whatever the taken flag is.
- R5: On a hit with the taken flag low, `hit` is 1 and `next_pc` equals `fetch_pc + 4`.
- R6: An install (`upd_en` = 1 at a rising edge) writes the valid flag, the tag and the target into the slot selected by `upd_pc`. It replaces any earlier occupant, and the new contents are seen by lookups from the next cycle on.
- R7: A lookup in the same cycle as an install to the same slot sees the slot's contents from before that install.
- R8: The byte-offset bits [1:0] of `fetch_pc` take no part in selecting the slot or in the tag compare.
- R9: The sequential address `fetch_pc + 4` wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, empties all slots |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | input | 1 | Direction prediction from the separate predictor |
| next_pc | output | 32 | Address to fetch on the next cycle |
| hit | output | 1 | Fetch address matched a valid slot |
| upd_en | input | 1 | Install a resolved taken branch this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Address the resolved branch jumped to |

## Verification
The assertions take for granted that `fetch_pc`, `pred_taken` and `upd_en` carry known 0/1 values in every cycle after reset. They also assume that an install is a plain clocked write, with no lookup-side effect on the table. The bench drives every input from a task at the falling edge, so all values are settled and defined before the next rising edge. Fetch and install addresses are drawn from three tags and all sixteen slot indices with random byte offsets, so that hits, aliasing replacements and same-slot collisions arise often, all inside those assumptions.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        LK_MISS     = 2'd0,
        LK_HIT_FALL = 2'd1,
        LK_HIT_JUMP = 2'd2
    } lookup_e;

endpackage

// File: rtl/btb_store.sv
module btb_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 26,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];

    genvar e;
    generate
        for (e = 0; e < DEPTH; e++) begin : g_slot
            logic sel;
            assign sel = wr_en && (wr_idx == IDX_W'(e));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[e] <= 1'b0;
                end else if (sel) begin
                    vld_q[e] <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (sel) begin
                    tag_q[e] <= wr_tag;
                    tgt_q[e] <= wr_target;
                end
            end
        end
    endgenerate

    // Read is combinational: a write in the same cycle lands at the edge, so the old contents are seen
    always_comb begin
        rd_valid  = vld_q[rd_idx];
        rd_tag    = tag_q[rd_idx];
        rd_target = tgt_q[rd_idx];
    end

    assert_install_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))
                  && (tgt_q[$past(wr_idx)] == $past(wr_target)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vld_q));

endmodule

// File: rtl/btb_match.sv
module btb_match
    import btb_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic             pred_taken,
    output lookup_e          kind
);
    logic same;

    always_comb begin
        same = slot_valid && (slot_tag == cur_tag);
        unique case ({same, pred_taken})
            2'b11:   kind = LK_HIT_JUMP;
            2'b10:   kind = LK_HIT_FALL;
            default: kind = LK_MISS;
        endcase
    end

endmodule

// File: rtl/btb_nextpc.sv
module btb_nextpc
    import btb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  lookup_e         kind,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [PC_W-1:0] slot_target,
    output logic [PC_W-1:0] nxt_pc,
    output logic            is_hit
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    always_comb begin
        unique case (kind)
            LK_HIT_JUMP: begin
                nxt_pc = slot_target;
                is_hit = 1'b1;
            end
            LK_HIT_FALL: begin
                nxt_pc = cur_pc + STEP;
                is_hit = 1'b1;
            end
            default: begin
                nxt_pc = cur_pc + STEP;
                is_hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int OFS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            pred_taken,
    output logic [PC_W-1:0] next_pc,
    output logic            hit,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target
);
    import btb_pkg::*;

    localparam int TAG_W = PC_W - IDX_W - OFS_W;
    localparam int TAG_LO = IDX_W + OFS_W;

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic [PC_W-1:0]  rd_target;
    lookup_e          kind;

    assign f_idx = fetch_pc[TAG_LO-1:OFS_W];
    assign f_tag = fetch_pc[PC_W-1:TAG_LO];
    assign u_idx = upd_pc[TAG_LO-1:OFS_W];
    assign u_tag = upd_pc[PC_W-1:TAG_LO];

    btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (f_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_target (rd_target),
        .wr_en     (upd_en),
        .wr_idx    (u_idx),
        .wr_tag    (u_tag),
        .wr_target (upd_target)
    );

    btb_match #(.TAG_W(TAG_W)) u_match (
        .slot_valid (rd_valid),
        .slot_tag   (rd_tag),
        .cur_tag    (f_tag),
        .pred_taken (pred_taken),
        .kind       (kind)
    );

    btb_nextpc #(.PC_W(PC_W)) u_next (
        .kind        (kind),
        .cur_pc      (fetch_pc),
        .slot_target (rd_target),
        .nxt_pc      (next_pc),
        .is_hit      (hit)
    );

    assert_miss_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (next_pc == fetch_pc + PC_W'(4)));

    assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && pred_taken) |-> (next_pc == rd_target));

    assert_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !pred_taken) |-> (next_pc == fetch_pc + PC_W'(4)));

    assert_hit_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (rd_valid && (rd_tag == f_tag)));

endmodule

// File: tb/tb_fetch_target_buffer.sv
module tb_fetch_target_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken = 1'b0;
    logic [31:0] next_pc;
    logic        hit;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [31:0] upd_target = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit m_vld [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_tgt [16];

    always #5 clk = ~clk;

    fetch_target_buffer dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
        .next_pc(next_pc), .hit(hit), .upd_en(upd_en), .upd_pc(upd_pc),
        .upd_target(upd_target)
    );

    function automatic bit exp_hit(input logic [31:0] pc);
        return m_vld[pc[5:2]] && (m_tag[pc[5:2]] == pc[31:6]);
    endfunction

    function automatic logic [31:0] exp_next(input logic [31:0] pc, input bit pt);
        if (exp_hit(pc) && pt) return m_tgt[pc[5:2]];
        return pc + 32'd4;
    endfunction

    task automatic check(input string req, input bit h_exp, input logic [31:0] n_exp);
        n_chk++;
        if (hit !== h_exp || next_pc !== n_exp) begin
            n_bad++;
            $display("FAIL %s: hit=%0b next_pc=%h expected hit=%0b next_pc=%h",
                     req, hit, next_pc, h_exp, n_exp);
        end
    endtask

    // One cycle: drive at falling edge, check the lookup against the pre-edge model, then commit
    task automatic step(input logic [31:0] fpc, input bit pt, input bit ue,
                        input logic [31:0] upc, input logic [31:0] utg, input string req);
        string tag;
        @(negedge clk);
        fetch_pc = fpc; pred_taken = pt; upd_en = ue; upd_pc = upc; upd_target = utg;
        #1;
        if (req != "") tag = req;
        else if (!exp_hit(fpc)) tag = "R4";
        else if (pt) tag = "R3";
        else tag = "R5";
        check(tag, exp_hit(fpc), exp_next(fpc, pt));
        @(posedge clk);
        if (ue) begin
            m_vld[upc[5:2]] = 1'b1;
            m_tag[upc[5:2]] = upc[31:6];
            m_tgt[upc[5:2]] = utg;
        end
    endtask

    function automatic logic [31:0] rnd_pc();
        logic [25:0] t;
        t = 26'h00AB00 + 26'($urandom % 3);
        return {t, 4'($urandom % 16), 2'($urandom % 4)};
    endfunction

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        // R1: lookups during and right after reset miss
        @(negedge clk);
        fetch_pc = 32'h0000_1000; pred_taken = 1'b1; #1;
        check("R1", 1'b0, 32'h0000_1004);
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        step(32'h0000_1000, 1'b1, 1'b0, '0, '0, "R1");
        step(32'h0000_2040, 1'b0, 1'b0, '0, '0, "R1");

        // R6 and R7: install, with a same-slot lookup in that cycle seeing the empty slot
        step(32'h0000_1000, 1'b1, 1'b1, 32'h0000_1000, 32'h0000_8000, "R7");
        step(32'h0000_1000, 1'b1, 1'b0, '0, '0, "R6");
        step(32'h0000_1000, 1'b0, 1'b0, '0, '0, "R5");
        // R8: byte offset ignored
        step(32'h0000_1003, 1'b1, 1'b0, '0, '0, "R8");
        // R2: same slot, other tag misses
        step(32'h0000_2000, 1'b1, 1'b0, '0, '0, "R2");
        // R7: replace while looking up the old owner, which still hits this cycle
        step(32'h0000_1000, 1'b1, 1'b1, 32'h0000_2000, 32'h0000_9000, "R7");
        step(32'h0000_1000, 1'b1, 1'b0, '0, '0, "R6");
        step(32'h0000_2000, 1'b1, 1'b0, '0, '0, "R6");
        // R9: wrap of the sequential address
        step(32'hFFFF_FFFC, 1'b1, 1'b0, '0, '0, "R9");
        step(32'hFFFF_FFFC, 1'b0, 1'b1, 32'hFFFF_FFFC, 32'h0000_0040, "R9");
        step(32'hFFFF_FFFC, 1'b0, 1'b0, '0, '0, "R9");
        step(32'hFFFF_FFFC, 1'b1, 1'b0, '0, '0, "R3");

        // Random mix: R3, R4, R5, R6, R7 all recur
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] f;
            bit ue;
            logic [31:0] u;
            f = rnd_pc();
            ue = ($urandom % 3) == 0;
            u = (($urandom % 4) == 0) ? f : rnd_pc();
            step(f, 1'($urandom % 2), ue, u, $urandom, "");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule